// File: doc/BRIEF.md
# NAND Flash Operation Engine

This block sits between a host register interface and an 8-bit NAND flash bus. It runs exactly one basic flash bus operation each time the host writes an operation code to its trigger register. The host first loads the command byte, address byte, area selection and timing configuration, then writes the trigger. It then polls the trigger register until the completion flag is set. The available operations are a single command cycle, a single address cycle, a buffered data transfer in either direction, a device identifier read and a status read.

Transfers go through an internal page buffer that the host reads and writes as 16-bit words. The buffer has four main areas of 512 bytes and, after them, four spare areas of 16 bytes. Within each word the even byte sits in the low half. Before an operation reports completion, the engine lets the flash busy line settle and then waits for the flash to become ready, so the host never watches the ready/busy pin itself. Setup and hold lengths of every write-enable and read-enable pulse come from the configuration register, counted in clock cycles.

Top module: `nand_op_engine`

## Requirements
- R1: After reset the flash pins are idle. Chip enable, write enable and read enable are high, command latch and address latch are low, and the data bus is not driven. All host registers read as zero.
- R2: Host word address 0x804 is the trigger register. Writing 0x0001 to it sends the command register byte (word 0x800, bits 7:0) as one write cycle with command latch high and address latch low. Write enable is low for setup+1 clock cycles and then high for hold+1 cycles. Setup is configuration bits 11:8 and hold is bits 15:12 (configuration register at word 0x803).
- R3: Writing 0x0002 to the trigger sends the address register byte (word 0x801) as one write cycle with address latch high and command latch low.
- R4: Writing 0x0004 to the trigger moves bytes from the buffer to the flash. The area is chosen by the select register (word 0x802, values 0 to 3). The engine sends the 512 main bytes of that area in ascending order, then its 16 spare bytes. Main area a, word w sits at buffer word a*256+w; spare area a, word w sits at buffer word 1024+a*8+w.
- R5: When configuration bit 2 is set, data input and data output cover only the 16 spare bytes of the selected area, and the main area stays untouched.
- R6: Writing 0x0008 to the trigger reads bytes from the flash into the selected area, in the same order and extent as R4. Each byte is sampled in the clock cycle just before read enable rises.
- R7: Writing 0x0010 to the trigger sends command 0x90, then address 0x00, then reads 4 identifier bytes into bytes 0 to 3 of main area 0, whatever the select register holds.
- R8: Writing 0x0020 to the trigger sends command 0x70 and reads one byte into the low half of word 0 of main area 1. The high half is left unchanged.
- R9: Trigger bit 15 is the completion flag. It becomes 1 on the same clock edge where chip enable returns high at the end of an operation. Writing the trigger with bit 15 at 0 clears it.
- R10: After the last bus cycle the engine waits a fixed settle time. It then waits for ready/busy to read high (through a two-stage synchroniser) before it reports completion.
- R11: Trigger bit 14 reads 1 while an operation runs. A trigger write made while busy starts nothing. A trigger value whose bits 5:0 are not exactly one-hot starts nothing.
- R12: Chip enable is low on every clock cycle in which write enable or read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | HOST_AW | Host word address; top bit set selects registers |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the address of the previous cycle |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, data taken on rising edge |
| nf_re_n | output | 1 | Read enable, active low |
| nf_dq_out | output | 8 | Data driven to flash |
| nf_dq_oe | output | 1 | Output enable for nf_dq_out |
| nf_dq_in | input | 8 | Data from flash |
| nf_rb_n | input | 1 | Flash ready (high) / busy (low) |

## Verification
The hardest state to reach from the ports is a trigger write landing while the engine is parked, waiting for the flash to become ready. To reach it, the bench's flash model pulls ready/busy low for 40 cycles after it latches command 0x10. While the line is low, the bench reads the busy bit and writes an address trigger. The scoreboard then confirms that no extra bus cycle appears, and the bench confirms that completion arrives only after the line is released. A spare-only read and a status read also run over buffer words that the bench filled beforehand, which shows that they leave the neighbouring bytes alone.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;
   typedef enum logic [5:0] {
      OP_NONE = 6'h00,
      OP_CMD  = 6'h01,
      OP_ADDR = 6'h02,
      OP_DIN  = 6'h04,
      OP_DOUT = 6'h08,
      OP_RID  = 6'h10,
      OP_STAT = 6'h20
   } op_e;

   typedef enum logic [2:0] {C_IDLE, C_ISSUE, C_WAIT, C_WB, C_RDY} ctl_e;
   typedef enum logic [1:0] {B_IDLE, B_LOW, B_HIGH} bus_e;

   localparam logic [2:0] REG_CMD  = 3'd0;
   localparam logic [2:0] REG_ADDR = 3'd1;
   localparam logic [2:0] REG_SEL  = 3'd2;
   localparam logic [2:0] REG_CFG  = 3'd3;
   localparam logic [2:0] REG_TRIG = 3'd4;
   localparam int TRIG_DONE_BIT = 15;
   localparam int CFG_SPARE_BIT = 2;
   localparam int TIME_W = 4;
endpackage

// File: rtl/nand_buf.sv
module nand_buf #(
   parameter int WORDS = 1056,
   parameter int AW    = 11,
   parameter int BA_W  = 12
) (
   input  logic            clk,
   input  logic [AW-1:0]   h_addr,
   input  logic            h_we,
   input  logic [15:0]     h_wdata,
   output logic [15:0]     h_rdata,
   input  logic [BA_W-1:0] e_baddr,
   input  logic            e_we,
   input  logic [7:0]      e_wbyte,
   output logic [7:0]      e_rbyte
);
   logic [15:0] mem [WORDS];
   logic [BA_W-2:0] e_word;
   assign e_word  = e_baddr[BA_W-1:1];
   assign e_rbyte = e_baddr[0] ? mem[e_word][15:8] : mem[e_word][7:0];

   always_ff @(posedge clk) begin
      if (h_we && (int'(h_addr) < WORDS)) mem[h_addr] <= h_wdata;
      if (e_we) begin
         if (e_baddr[0]) mem[e_word][15:8] <= e_wbyte;
         else            mem[e_word][7:0]  <= e_wbyte;
      end
      h_rdata <= (int'(h_addr) < WORDS) ? mem[h_addr] : 16'h0000;
   end
endmodule

// File: rtl/nand_cycle.sv
module nand_cycle
   import nand_eng_pkg::*;
#(
   parameter int CNT_W = TIME_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rd_i,
   input  logic             cle_i,
   input  logic             ale_i,
   input  logic [7:0]       wdata_i,
   input  logic [CNT_W-1:0] setup_i,
   input  logic [CNT_W-1:0] hold_i,
   output logic             done_o,
   output logic [7:0]       rdata_o,
   output logic             we_n_o,
   output logic             re_n_o,
   output logic             cle_o,
   output logic             ale_o,
   output logic [7:0]       dq_o,
   output logic             dq_oe_o,
   input  logic [7:0]       dq_i
);
   bus_e             st;
   logic [CNT_W-1:0] cnt;
   logic             rd_q, cle_q, ale_q, active;
   logic [7:0]       dq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= B_IDLE; cnt <= '0; rd_q <= 1'b0; cle_q <= 1'b0; ale_q <= 1'b0;
         dq_q <= '0; rdata_o <= '0; done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            B_IDLE: if (start_i) begin
               st <= B_LOW; cnt <= setup_i; rd_q <= rd_i;
               cle_q <= cle_i; ale_q <= ale_i; dq_q <= wdata_i;
            end
            B_LOW: if (cnt == '0) begin
               st <= B_HIGH; cnt <= hold_i;
               if (rd_q) rdata_o <= dq_i;
            end else cnt <= cnt - 1'b1;
            B_HIGH: if (cnt == '0) begin
               st <= B_IDLE; done_o <= 1'b1;
            end else cnt <= cnt - 1'b1;
            default: st <= B_IDLE;
         endcase
      end
   end

   assign active  = (st != B_IDLE);
   assign we_n_o  = !(st == B_LOW && !rd_q);
   assign re_n_o  = !(st == B_LOW && rd_q);
   assign cle_o   = active && cle_q;
   assign ale_o   = active && ale_q;
   assign dq_o    = dq_q;
   assign dq_oe_o = active && !rd_q;

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (st == B_IDLE)); // R2
   AST_CLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cle_o |-> re_n_o); // R2
   AST_NO_CLE_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle_o && ale_o)); // R3
endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nand_eng_pkg::*;
#(
   parameter int AREAS       = 4,
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int ID_BYTES    = 4,
   parameter int WB_CYCLES   = 4,
   parameter logic [7:0] ID_CMD   = 8'h90,
   parameter logic [7:0] STAT_CMD = 8'h70,
   parameter int BA_W        = 12,
   parameter int SEL_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  op_e               op_i,
   input  logic [7:0]        cmd_i,
   input  logic [7:0]        addr_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              spare_i,
   input  logic [TIME_W-1:0] setup_i,
   input  logic [TIME_W-1:0] hold_i,
   input  logic              rb_i,
   output logic              busy_o,
   output logic              fin_o,
   output logic              cyc_start_o,
   output logic              cyc_rd_o,
   output logic              cyc_cle_o,
   output logic              cyc_ale_o,
   output logic [7:0]        cyc_wdata_o,
   output logic [TIME_W-1:0] cyc_setup_o,
   output logic [TIME_W-1:0] cyc_hold_o,
   input  logic              cyc_done_i,
   input  logic [7:0]        cyc_rdata_i,
   output logic [BA_W-1:0]   e_baddr_o,
   output logic              e_we_o,
   output logic [7:0]        e_wbyte_o,
   input  logic [7:0]        e_rbyte_i
);
   localparam int IDX_W = $clog2(MAIN_BYTES + SPARE_BYTES + ID_BYTES + 3);
   localparam int WB_W  = $clog2(WB_CYCLES + 1);
   localparam logic [BA_W-1:0] SPARE_BASE = BA_W'(AREAS * MAIN_BYTES);

   ctl_e             st;
   op_e              op_q;
   logic [7:0]       cmd_q, addr_q;
   logic [SEL_W-1:0] sel_q;
   logic             spare_q;
   logic [IDX_W-1:0] idx, n_pre, n_dat, total, jdx;
   logic [WB_W-1:0]  wb;
   logic             is_pre;

   always_comb begin
      unique case (op_q)
         OP_CMD, OP_ADDR, OP_STAT: n_pre = IDX_W'(1);
         OP_RID:                   n_pre = IDX_W'(2);
         default:                  n_pre = '0;
      endcase
      unique case (op_q)
         OP_DIN, OP_DOUT: n_dat = spare_q ? IDX_W'(SPARE_BYTES) : IDX_W'(MAIN_BYTES + SPARE_BYTES);
         OP_RID:          n_dat = IDX_W'(ID_BYTES);
         OP_STAT:         n_dat = IDX_W'(1);
         default:         n_dat = '0;
      endcase
   end
   assign total  = n_pre + n_dat;
   assign is_pre = (idx < n_pre);
   assign jdx    = idx - n_pre;

   always_comb begin
      if (op_q == OP_RID)
         e_baddr_o = BA_W'(jdx);
      else if (op_q == OP_STAT)
         e_baddr_o = BA_W'(MAIN_BYTES);
      else if (spare_q)
         e_baddr_o = SPARE_BASE + BA_W'(sel_q) * BA_W'(SPARE_BYTES) + BA_W'(jdx);
      else if (jdx >= IDX_W'(MAIN_BYTES))
         e_baddr_o = SPARE_BASE + BA_W'(sel_q) * BA_W'(SPARE_BYTES) + BA_W'(jdx) - BA_W'(MAIN_BYTES);
      else
         e_baddr_o = BA_W'(sel_q) * BA_W'(MAIN_BYTES) + BA_W'(jdx);
   end

   always_comb begin
      cyc_rd_o = 1'b0; cyc_cle_o = 1'b0; cyc_ale_o = 1'b0; cyc_wdata_o = e_rbyte_i;
      if (is_pre) begin
         unique case (op_q)
            OP_CMD:  begin cyc_cle_o = 1'b1; cyc_wdata_o = cmd_q; end
            OP_ADDR: begin cyc_ale_o = 1'b1; cyc_wdata_o = addr_q; end
            OP_STAT: begin cyc_cle_o = 1'b1; cyc_wdata_o = STAT_CMD; end
            OP_RID: begin
               cyc_cle_o   = (idx == '0);
               cyc_ale_o   = (idx != '0);
               cyc_wdata_o = (idx == '0) ? ID_CMD : 8'h00;
            end
            default: ;
         endcase
      end else begin
         cyc_rd_o = (op_q != OP_DIN);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= C_IDLE; op_q <= OP_NONE; cmd_q <= '0; addr_q <= '0; sel_q <= '0;
         spare_q <= 1'b0; cyc_setup_o <= '0; cyc_hold_o <= '0; idx <= '0; wb <= '0;
      end else begin
         unique case (st)
            C_IDLE: if (start_i) begin
               st <= C_ISSUE; op_q <= op_i; cmd_q <= cmd_i; addr_q <= addr_i;
               sel_q <= sel_i; spare_q <= spare_i; cyc_setup_o <= setup_i;
               cyc_hold_o <= hold_i; idx <= '0;
            end
            C_ISSUE: st <= C_WAIT;
            C_WAIT: if (cyc_done_i) begin
               if (idx == total - 1'b1) begin st <= C_WB; wb <= '0; end
               else begin idx <= idx + 1'b1; st <= C_ISSUE; end
            end
            C_WB: if (wb == WB_W'(WB_CYCLES - 1)) st <= C_RDY;
                  else wb <= wb + 1'b1;
            C_RDY: if (rb_i) st <= C_IDLE;
            default: st <= C_IDLE;
         endcase
      end
   end

   assign busy_o      = (st != C_IDLE);
   assign fin_o       = (st == C_RDY) && rb_i;
   assign cyc_start_o = (st == C_ISSUE);
   assign e_we_o      = (st == C_WAIT) && cyc_done_i && cyc_rd_o;
   assign e_wbyte_o   = cyc_rdata_i;

   AST_ONEHOT_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_q)); // R11
   AST_FILL_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
      (e_we_o && op_q == OP_RID) |-> (e_baddr_o < BA_W'(MAIN_BYTES))); // R7
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
   import nand_eng_pkg::*;
#(
   parameter int AREAS       = 4,
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int ID_BYTES    = 4,
   parameter int WB_CYCLES   = 4,
   parameter int RB_SYNC     = 1,
   parameter logic [7:0] ID_CMD   = 8'h90,
   parameter logic [7:0] STAT_CMD = 8'h70,
   parameter int HOST_AW     = $clog2(AREAS * (MAIN_BYTES + SPARE_BYTES) / 2) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic [15:0]        host_wdata,
   output logic [15:0]        host_rdata,
   output logic               nf_ce_n,
   output logic               nf_cle,
   output logic               nf_ale,
   output logic               nf_we_n,
   output logic               nf_re_n,
   output logic [7:0]         nf_dq_out,
   output logic               nf_dq_oe,
   input  logic [7:0]         nf_dq_in,
   input  logic               nf_rb_n
);
   localparam int TOTAL_BYTES = AREAS * (MAIN_BYTES + SPARE_BYTES);
   localparam int BUF_WORDS   = TOTAL_BYTES / 2;
   localparam int BUF_AW      = HOST_AW - 1;
   localparam int BA_W        = $clog2(TOTAL_BYTES);
   localparam int SEL_W       = $clog2(AREAS);

   if (MAIN_BYTES % 2 != 0 || SPARE_BYTES % 2 != 0) begin : g_bad_even
      $error("area sizes must be even");
   end
   if (AREAS < 2 || ID_BYTES < 1 || ID_BYTES > MAIN_BYTES) begin : g_bad_size
      $error("need two areas and an id length within one main area");
   end
   if (WB_CYCLES < 1) begin : g_bad_wb
      $error("settle time must be at least one cycle");
   end
   if ((1 << BUF_AW) < BUF_WORDS) begin : g_bad_aw
      $error("host address too narrow for the buffer");
   end

   logic [7:0]        cmd_r, addr_r;
   logic [SEL_W-1:0]  sel_r;
   logic              spare_r, done_r, busy, fin, reg_sel_q, rb_s;
   logic [TIME_W-1:0] setup_r, hold_r;
   logic [15:0]       reg_rd_q, buf_rd;
   logic              reg_hit, trig_wr, start;
   logic [2:0]        roff;

   assign reg_hit = host_addr[HOST_AW-1];
   assign roff    = host_addr[2:0];
   assign trig_wr = host_wr && reg_hit && (roff == REG_TRIG);
   assign start   = trig_wr && ($countones(host_wdata[5:0]) == 1) && !busy;

   if (RB_SYNC != 0) begin : g_rb_sync
      logic [1:0] s;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) s <= 2'b00;
         else        s <= {s[0], nf_rb_n};
      assign rb_s = s[1];
   end else begin : g_rb_raw
      assign rb_s = nf_rb_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_r <= '0; addr_r <= '0; sel_r <= '0; spare_r <= 1'b0;
         setup_r <= '0; hold_r <= '0; done_r <= 1'b0;
         reg_rd_q <= '0; reg_sel_q <= 1'b0;
      end else begin
         if (host_wr && reg_hit) begin
            unique case (roff)
               REG_CMD:  cmd_r  <= host_wdata[7:0];
               REG_ADDR: addr_r <= host_wdata[7:0];
               REG_SEL:  sel_r  <= host_wdata[SEL_W-1:0];
               REG_CFG: begin
                  spare_r <= host_wdata[CFG_SPARE_BIT];
                  setup_r <= host_wdata[11:8];
                  hold_r  <= host_wdata[15:12];
               end
               REG_TRIG: if (!host_wdata[TRIG_DONE_BIT]) done_r <= 1'b0;
               default: ;
            endcase
         end
         if (fin) done_r <= 1'b1;
         reg_sel_q <= reg_hit;
         unique case (roff)
            REG_CMD:  reg_rd_q <= {8'h00, cmd_r};
            REG_ADDR: reg_rd_q <= {8'h00, addr_r};
            REG_SEL:  reg_rd_q <= 16'(sel_r);
            REG_CFG:  reg_rd_q <= {hold_r, setup_r, 5'b0, spare_r, 2'b0};
            REG_TRIG: reg_rd_q <= {done_r, busy, 14'b0};
            default:  reg_rd_q <= 16'h0000;
         endcase
      end
   end
   assign host_rdata = reg_sel_q ? reg_rd_q : buf_rd;

   logic              c_start, c_rd, c_cle, c_ale, c_done;
   logic [7:0]        c_wdata, c_rdata, e_wbyte, e_rbyte;
   logic [TIME_W-1:0] c_setup, c_hold;
   logic [BA_W-1:0]   e_baddr;
   logic              e_we;

   nand_buf #(.WORDS(BUF_WORDS), .AW(BUF_AW), .BA_W(BA_W)) u_buf (
      .clk(clk), .h_addr(host_addr[BUF_AW-1:0]), .h_we(host_wr && !reg_hit),
      .h_wdata(host_wdata), .h_rdata(buf_rd), .e_baddr(e_baddr), .e_we(e_we),
      .e_wbyte(e_wbyte), .e_rbyte(e_rbyte));

   nand_seq #(.AREAS(AREAS), .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
      .ID_BYTES(ID_BYTES), .WB_CYCLES(WB_CYCLES), .ID_CMD(ID_CMD),
      .STAT_CMD(STAT_CMD), .BA_W(BA_W), .SEL_W(SEL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_e'(host_wdata[5:0])),
      .cmd_i(cmd_r), .addr_i(addr_r), .sel_i(sel_r), .spare_i(spare_r),
      .setup_i(setup_r), .hold_i(hold_r), .rb_i(rb_s), .busy_o(busy), .fin_o(fin),
      .cyc_start_o(c_start), .cyc_rd_o(c_rd), .cyc_cle_o(c_cle), .cyc_ale_o(c_ale),
      .cyc_wdata_o(c_wdata), .cyc_setup_o(c_setup), .cyc_hold_o(c_hold),
      .cyc_done_i(c_done), .cyc_rdata_i(c_rdata), .e_baddr_o(e_baddr),
      .e_we_o(e_we), .e_wbyte_o(e_wbyte), .e_rbyte_i(e_rbyte));

   nand_cycle #(.CNT_W(TIME_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .start_i(c_start), .rd_i(c_rd), .cle_i(c_cle),
      .ale_i(c_ale), .wdata_i(c_wdata), .setup_i(c_setup), .hold_i(c_hold),
      .done_o(c_done), .rdata_o(c_rdata), .we_n_o(nf_we_n), .re_n_o(nf_re_n),
      .cle_o(nf_cle), .ale_o(nf_ale), .dq_o(nf_dq_out), .dq_oe_o(nf_dq_oe),
      .dq_i(nf_dq_in));

   assign nf_ce_n = !busy;

   AST_CE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R12
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_r) |-> $past(nf_rb_n, 1 + 2 * RB_SYNC)); // R10
   AST_DONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_r) |-> nf_ce_n); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_wr && busy && !fin) |=> busy); // R11
endmodule

// File: tb/sim_nand_op_engine.sv
`timescale 1ns/1ps
module sim_nand_op_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] host_addr = '0;
   logic        host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [7:0]  nf_dq_out, nf_dq_in;
   logic        nf_rb_n = 1'b1;

   int total = 0, bad = 0;
   bit armed = 0;
   int exp_low = 1;
   int rd_idx = 0, rd_start = 0, rd_base = 0;
   time t_low = 0, t_prog = 0;
   logic [9:0] sb_q[$];

   always #2 clk = ~clk;

   nand_op_engine u0 (.*);

   function automatic logic [7:0] pat(int base, int k);
      return 8'(base + k * 13 + 5);
   endfunction
   assign nf_dq_in = pat(rd_base, rd_idx - rd_start);

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every write-enable rise is compared with the queue
   always @(negedge nf_we_n) t_low = $time;
   always @(posedge nf_we_n) if (armed) begin
      chk(((($time - t_low) / 4) == exp_low), "R2 we_n low width", int'(($time - t_low) / 4), exp_low);
      chk(!nf_ce_n, "R12 ce_n low during strobe", nf_ce_n, 0);
      if (sb_q.size() == 0)
         chk(0, "R11 unexpected bus cycle", {nf_cle, nf_ale, nf_dq_out}, 0);
      else begin
         logic [9:0] e;
         e = sb_q.pop_front();
         chk({nf_cle, nf_ale, nf_dq_out} == e, "R2/R3/R4 bus cycle", {nf_cle, nf_ale, nf_dq_out}, e);
      end
   end
   always @(posedge nf_re_n) if (armed) begin
      chk(!nf_ce_n, "R12 ce_n low during read", nf_ce_n, 0);
      rd_idx++;
   end
   // flash model: program confirm keeps the part busy for 40 cycles
   always @(posedge nf_we_n) if (armed && nf_cle && nf_dq_out == 8'h10) begin
      t_prog = $time;
      nf_rb_n = 1'b0;
      repeat (40) @(negedge clk);
      nf_rb_n = 1'b1;
   end

   task automatic wr(int a, logic [15:0] d);
      @(negedge clk); host_addr = 12'(a); host_wdata = d; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0;
   endtask
   task automatic rd(int a, output logic [15:0] d);
      @(negedge clk); host_addr = 12'(a);
      @(negedge clk); d = host_rdata;
   endtask
   task automatic push(bit c, bit a, logic [7:0] b);
      sb_q.push_back({c, a, b});
   endtask
   task automatic wait_done();
      logic [15:0] v;
      for (int i = 0; i < 8000; i++) begin
         rd(12'h804, v);
         if (v[15]) break;
      end
      chk(v[15] == 1'b1, "R9 done flag set", v, 16'h8000);
      chk(nf_ce_n == 1'b1, "R9 ce_n high after done", nf_ce_n, 1);
      wr(12'h804, 16'h0000);
   endtask

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int mism;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe,
          "R1 idle pins", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 6'b111000);
      for (int r = 0; r < 5; r++) begin
         rd(12'h800 + r, v);
         chk(v == 16'h0, "R1 register zero", v, 0);
      end
      armed = 1;

      // R2 command cycle with setup 2, hold 1
      wr(12'h803, 16'h1200); exp_low = 3;
      wr(12'h800, 16'h003C); push(1, 0, 8'h3C);
      wr(12'h804, 16'h0001); wait_done();
      rd(12'h804, v); chk(v == 16'h0, "R9 done cleared", v, 0);

      // R3 address cycle
      wr(12'h801, 16'h005A); push(0, 1, 8'h5A);
      wr(12'h804, 16'h0002); wait_done();

      // R4 full data input from area 2
      wr(12'h803, 16'h0000); exp_low = 1;
      for (int w = 0; w < 256; w++)
         wr(2 * 256 + w, {8'(2 * w * 7 + 10), 8'(2 * w * 7 + 3)});
      for (int w = 0; w < 8; w++)
         wr(1024 + 2 * 8 + w, {8'(8'hA1 + 2 * w), 8'(8'hA0 + 2 * w)});
      for (int j = 0; j < 512; j++) push(0, 0, 8'(j * 7 + 3));
      for (int j = 0; j < 16; j++) push(0, 0, 8'(8'hA0 + j));
      wr(12'h802, 16'h0002); wr(12'h804, 16'h0004); wait_done();
      chk(sb_q.size() == 0, "R4 all bytes sent", sb_q.size(), 0);

      // R5 spare-only data input from area 1
      wr(12'h803, 16'h0004);
      for (int w = 0; w < 8; w++)
         wr(1024 + 8 + w, {8'(8'h51 + 2 * w), 8'(8'h50 + 2 * w)});
      for (int j = 0; j < 16; j++) push(0, 0, 8'(8'h50 + j));
      wr(12'h802, 16'h0001); wr(12'h804, 16'h0004); wait_done();
      chk(sb_q.size() == 0, "R5 spare bytes only", sb_q.size(), 0);

      // R6 full data output into area 3
      wr(12'h803, 16'h0000); wr(12'h802, 16'h0003);
      rd_base = 8'h11; rd_start = rd_idx;
      wr(12'h804, 16'h0008); wait_done();
      mism = 0;
      for (int w = 0; w < 256; w++) begin
         rd(3 * 256 + w, v);
         if (v != {pat(8'h11, 2 * w + 1), pat(8'h11, 2 * w)}) mism++;
      end
      for (int w = 0; w < 8; w++) begin
         rd(1024 + 3 * 8 + w, v);
         if (v != {pat(8'h11, 512 + 2 * w + 1), pat(8'h11, 512 + 2 * w)}) mism++;
      end
      chk(mism == 0, "R6 read data in area 3", mism, 0);

      // R5 spare-only data output into area 0, main untouched
      wr(0, 16'hBEEF);
      wr(12'h803, 16'h0004); wr(12'h802, 16'h0000);
      rd_base = 8'h40; rd_start = rd_idx;
      wr(12'h804, 16'h0008); wait_done();
      mism = 0;
      for (int w = 0; w < 8; w++) begin
         rd(1024 + w, v);
         if (v != {pat(8'h40, 2 * w + 1), pat(8'h40, 2 * w)}) mism++;
      end
      chk(mism == 0, "R5 spare read data", mism, 0);
      rd(0, v); chk(v == 16'hBEEF, "R5 main area untouched", v, 16'hBEEF);

      // R7 read ID into main area 0 although select is 3
      wr(12'h803, 16'h0000); wr(12'h802, 16'h0003);
      push(1, 0, 8'h90); push(0, 1, 8'h00);
      rd_base = 8'h77; rd_start = rd_idx;
      wr(12'h804, 16'h0010); wait_done();
      rd(0, v); chk(v == {pat(8'h77, 1), pat(8'h77, 0)}, "R7 id word 0", v, {pat(8'h77, 1), pat(8'h77, 0)});
      rd(1, v); chk(v == {pat(8'h77, 3), pat(8'h77, 2)}, "R7 id word 1", v, {pat(8'h77, 3), pat(8'h77, 2)});

      // R8 read status into main area 1 word 0 low byte
      wr(256, 16'hAB00);
      push(1, 0, 8'h70);
      rd_base = 8'hC3; rd_start = rd_idx;
      wr(12'h804, 16'h0020); wait_done();
      rd(256, v); chk(v == {8'hAB, pat(8'hC3, 0)}, "R8 status word", v, {8'hAB, pat(8'hC3, 0)});

      // R11 non-one-hot trigger starts nothing
      wr(12'h804, 16'h0003);
      rd(12'h804, v); chk(v == 16'h0, "R11 no start on 0x0003", v, 0);

      // R10/R11 trigger while waiting for ready
      wr(12'h800, 16'h0010); push(1, 0, 8'h10);
      wr(12'h804, 16'h0001);
      repeat (20) @(negedge clk);
      rd(12'h804, v); chk(v == 16'h4000, "R11 busy while flash busy", v, 16'h4000);
      wr(12'h804, 16'h0002);
      wait_done();
      chk((($time - t_prog) / 4) >= 40, "R10 done after ready", int'(($time - t_prog) / 4), 40);
      repeat (20) @(negedge clk);
      chk(sb_q.size() == 0, "R11 ignored trigger produced nothing", sb_q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule